// File: doc/BRIEF.md
# USB Host Controller Register File

This block is the I/O-mapped register set of a simple full-speed USB host controller. It holds the command, status, interrupt-enable, frame-number, frame-list-base and start-of-frame timing registers. Software reaches them through a 32-byte window that accepts byte, word and dword accesses. Read data is registered and appears on `rdata_o` in the cycle after the read strobe.

A separate frame engine uses this block. It reads `run_o` to know when to walk the schedule. It pulses `frame_tick_i` once per frame, with the interrupt causes gathered in that frame on `frame_cause_i`. It also pulses `xfer_err_i`, `host_err_i`, `proc_err_i` and `resume_i` when those events occur. A hidden two-bit cause latch keeps completion interrupts apart from short-packet interrupts. The block combines the latch, the status bits and the enable bits into one registered, level-sensitive interrupt line.

Top module: `usbh_regfile`

## Requirements
- R1: After `rst` the command, status, interrupt-enable, frame-number and frame-list-base registers read 0, the start-of-frame timing reads 0x40, and `irq_o` and `run_o` are low.
- R2: Only the low 5 address bits are decoded. The size code is 0 for byte, 1 for word and 2 for dword. A write whose size does not match the register at its offset is ignored. Reads of offsets with no register of that size return 0xFF for a byte, 0xFF7F for a word and 0xFFFFFFFF for a dword or size code 3.
- R3: A word write to offset 0x00 stores the command. `run_o` follows command bit 0. Writing bit 0 as 0 sets status bit 5 (halted). A 0-to-1 change of bit 0 clears status bit 5.
- R4: A command write with bit 1 or bit 2 set stores nothing. Instead it returns command, status, cause latch, interrupt enable, frame-list base and start-of-frame timing to their reset values, and the frame number is kept.
- R5: A word write to offset 0x02 clears each status bit written as 1 and leaves bits written as 0 unchanged. Writing 1 to bit 0 also empties the cause latch.
- R6: A word write to offset 0x06 loads the low 11 bits of the frame number, but only while status bit 5 is set. `frame_tick_i` increments the frame number modulo 2048.
- R7: On `frame_tick_i` with a non-zero `frame_cause_i`, the mask is ORed into the cause latch and status bit 0 is set.
- R8: `xfer_err_i` sets status bit 1, `host_err_i` sets status bit 3 and `proc_err_i` sets status bit 4.
- R9: `resume_i` while command bit 3 is set sets command bit 4 and status bit 2. While command bit 3 is clear, `resume_i` has no effect.
- R10: A dword write to offset 0x08 stores the frame-list base, and its low 12 bits always read as 0. Byte offset 0x0C holds the 8-bit start-of-frame timing.
- R11: `irq_o` is high one cycle after any of these holds: cause bit 0 with enable bit 2, cause bit 1 with enable bit 3, status bit 1 with enable bit 0, status bit 2 with enable bit 1, status bit 3, or status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ABUS_W | Byte address; low 5 bits decoded |
| size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| wdata_i | input | 32 | Write data, right-aligned |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| run_o | output | 1 | Run/stop to the frame engine |
| frame_tick_i | input | 1 | End-of-frame pulse, advances frame number |
| frame_cause_i | input | 2 | Interrupt causes pending at end of frame |
| xfer_err_i | input | 1 | Transfer error event |
| host_err_i | input | 1 | Host system error event |
| proc_err_i | input | 1 | Schedule process error event |
| resume_i | input | 1 | Resume signalling detected |
| frame_no_o | output | 11 | Current frame number |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The interrupt line is computed from hidden state, so a corrupted cause latch is visible only through `irq_o`. A status or enable fault also shows there, exactly one cycle after the offending event. The bench therefore checks the line after each cause, enable change and clear, while holding the other sources fixed. A fault in the halt flag shows in two places: the next status read, and the frame number accepting or refusing a load. A decoder fault shows on the next read of the aliased or mismatched access.

// File: rtl/usbh_pkg.sv
package usbh_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } xfer_size_e;

  typedef enum logic [3:0] {
    RD_ONES_B, RD_ONES_W, RD_ONES_D,
    RD_CMD, RD_STS, RD_IEN, RD_FRN, RD_BASE, RD_SOF
  } rd_sel_e;

  localparam int WIN_W = 5;
  localparam logic [WIN_W-1:0] OFS_CMD  = 5'h00;
  localparam logic [WIN_W-1:0] OFS_STS  = 5'h02;
  localparam logic [WIN_W-1:0] OFS_IEN  = 5'h04;
  localparam logic [WIN_W-1:0] OFS_FRN  = 5'h06;
  localparam logic [WIN_W-1:0] OFS_BASE = 5'h08;
  localparam logic [WIN_W-1:0] OFS_SOF  = 5'h0C;

  localparam int CMD_RUN   = 0;
  localparam int CMD_HCRST = 1;
  localparam int CMD_GRST  = 2;
  localparam int CMD_SUSP  = 3;
  localparam int CMD_FRES  = 4;

  localparam int ST_INT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_RES  = 2;
  localparam int ST_HSE  = 3;
  localparam int ST_HPE  = 4;
  localparam int ST_HALT = 5;
  localparam int ST_W    = 6;
endpackage

// File: rtl/usbh_bus_decode.sv
module usbh_bus_decode
  import usbh_pkg::*;
#(
  parameter int ABUS_W = 16
) (
  input  logic              wr_i,
  input  logic [ABUS_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              wr_cmd_o,
  output logic              wr_sts_o,
  output logic              wr_ien_o,
  output logic              wr_frn_o,
  output logic              wr_base_o,
  output logic              wr_sof_o,
  output rd_sel_e           rd_sel_o
);
  logic [WIN_W-1:0] ofs;
  xfer_size_e       sz;
  logic             unused_addr_hi;

  assign ofs = addr_i[WIN_W-1:0];
  assign sz  = xfer_size_e'(size_i);

  generate
    if (ABUS_W > WIN_W) begin : g_hi
      assign unused_addr_hi = ^addr_i[ABUS_W-1:WIN_W];
    end else begin : g_nohi
      assign unused_addr_hi = 1'b0;
    end
  endgenerate

  assign wr_cmd_o  = wr_i && (sz == SZ_WORD)  && (ofs == OFS_CMD);
  assign wr_sts_o  = wr_i && (sz == SZ_WORD)  && (ofs == OFS_STS);
  assign wr_ien_o  = wr_i && (sz == SZ_WORD)  && (ofs == OFS_IEN);
  assign wr_frn_o  = wr_i && (sz == SZ_WORD)  && (ofs == OFS_FRN);
  assign wr_base_o = wr_i && (sz == SZ_DWORD) && (ofs == OFS_BASE);
  assign wr_sof_o  = wr_i && (sz == SZ_BYTE)  && (ofs == OFS_SOF);

  always_comb begin
    rd_sel_o = RD_ONES_D;
    case (sz)
      SZ_BYTE:  rd_sel_o = (ofs == OFS_SOF) ? RD_SOF : RD_ONES_B;
      SZ_WORD: begin
        case (ofs)
          OFS_CMD: rd_sel_o = RD_CMD;
          OFS_STS: rd_sel_o = RD_STS;
          OFS_IEN: rd_sel_o = RD_IEN;
          OFS_FRN: rd_sel_o = RD_FRN;
          default: rd_sel_o = RD_ONES_W;
        endcase
      end
      SZ_DWORD: rd_sel_o = (ofs == OFS_BASE) ? RD_BASE : RD_ONES_D;
      default:  rd_sel_o = RD_ONES_D;
    endcase
  end
endmodule

// File: rtl/usbh_frame_ctr.sv
module usbh_frame_ctr #(
  parameter int FN_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic            ld_i,
  input  logic [FN_W-1:0] ld_val_i,
  output logic [FN_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (tick_i) q_o <= q_o + 1'b1;
    else if (ld_i)   q_o <= ld_val_i;
  end

  // R6
  frn_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> (q_o == FN_W'($past(q_o) + 1'b1)));

  // R6
  frn_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_i && !tick_i) |=> (q_o == $past(ld_val_i)));
endmodule

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cause_i,
  input  logic [3:0] ien_i,
  input  logic       sts_err_i,
  input  logic       sts_res_i,
  input  logic       sts_hse_i,
  input  logic       sts_hpe_i,
  output logic       irq_o
);
  logic [5:0] src;

  assign src = {sts_hpe_i,
                sts_hse_i,
                sts_res_i & ien_i[1],
                sts_err_i & ien_i[0],
                cause_i[1] & ien_i[3],
                cause_i[0] & ien_i[2]};

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |src;
  end

  // R11
  fatal_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_hse_i || sts_hpe_i) |=> irq_o);

  // R11
  quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ien_i == 4'd0 && !sts_hse_i && !sts_hpe_i) |=> !irq_o);
endmodule

// File: rtl/usbh_regfile.sv
module usbh_regfile
  import usbh_pkg::*;
#(
  parameter int ABUS_W     = 16,
  parameter int FN_W       = 11,
  parameter int BASE_ALIGN = 12,
  parameter int SOF_W      = 8,
  parameter int SOF_RESET  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ABUS_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              run_o,
  input  logic              frame_tick_i,
  input  logic [1:0]        frame_cause_i,
  input  logic              xfer_err_i,
  input  logic              host_err_i,
  input  logic              proc_err_i,
  input  logic              resume_i,
  output logic [FN_W-1:0]   frame_no_o,
  output logic              irq_o
);
  localparam int BASE_HI_W = 32 - BASE_ALIGN;
  localparam logic [SOF_W-1:0] SOF_DEF = SOF_W'(SOF_RESET);

  logic wr_cmd, wr_sts, wr_ien, wr_frn, wr_base, wr_sof, soft_rst;
  rd_sel_e rd_sel;

  logic [15:0]          cmd_q, cmd_nxt;
  logic [ST_W-1:0]      sts_q, sts_nxt;
  logic [1:0]           cause_q, cause_nxt;
  logic [15:0]          ien_q;
  logic [BASE_HI_W-1:0] base_q;
  logic [SOF_W-1:0]     sof_q;

  usbh_bus_decode #(.ABUS_W(ABUS_W)) u_dec (
    .wr_i(wr_i), .addr_i(addr_i), .size_i(size_i),
    .wr_cmd_o(wr_cmd), .wr_sts_o(wr_sts), .wr_ien_o(wr_ien),
    .wr_frn_o(wr_frn), .wr_base_o(wr_base), .wr_sof_o(wr_sof),
    .rd_sel_o(rd_sel)
  );

  assign soft_rst = wr_cmd && (wdata_i[CMD_HCRST] || wdata_i[CMD_GRST]);

  always_comb begin
    cmd_nxt   = cmd_q;
    sts_nxt   = sts_q;
    cause_nxt = cause_q;
    if (wr_cmd) begin
      cmd_nxt = wdata_i[15:0];
      if (wdata_i[CMD_RUN] && !cmd_q[CMD_RUN]) sts_nxt[ST_HALT] = 1'b0;
      else if (!wdata_i[CMD_RUN])              sts_nxt[ST_HALT] = 1'b1;
    end
    if (wr_sts) begin
      sts_nxt = sts_nxt & ~wdata_i[ST_W-1:0];
      if (wdata_i[ST_INT]) cause_nxt = 2'b00;
    end
    if (frame_tick_i && (frame_cause_i != 2'b00)) begin
      cause_nxt       = cause_nxt | frame_cause_i;
      sts_nxt[ST_INT] = 1'b1;
    end
    if (xfer_err_i) sts_nxt[ST_ERR] = 1'b1;
    if (host_err_i) sts_nxt[ST_HSE] = 1'b1;
    if (proc_err_i) sts_nxt[ST_HPE] = 1'b1;
    if (resume_i && cmd_q[CMD_SUSP]) begin
      cmd_nxt[CMD_FRES] = 1'b1;
      sts_nxt[ST_RES]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cmd_q   <= '0;
      sts_q   <= '0;
      cause_q <= '0;
      ien_q   <= '0;
      base_q  <= '0;
      sof_q   <= SOF_DEF;
    end else begin
      cmd_q   <= cmd_nxt;
      sts_q   <= sts_nxt;
      cause_q <= cause_nxt;
      if (wr_ien)  ien_q  <= wdata_i[15:0];
      if (wr_base) base_q <= wdata_i[31:BASE_ALIGN];
      if (wr_sof)  sof_q  <= wdata_i[SOF_W-1:0];
    end
  end

  usbh_frame_ctr #(.FN_W(FN_W)) u_frn (
    .clk(clk), .rst(rst), .tick_i(frame_tick_i),
    .ld_i(wr_frn && sts_q[ST_HALT]),
    .ld_val_i(wdata_i[FN_W-1:0]),
    .q_o(frame_no_o)
  );

  usbh_irq_gen u_irq (
    .clk(clk), .rst(rst), .cause_i(cause_q), .ien_i(ien_q[3:0]),
    .sts_err_i(sts_q[ST_ERR]), .sts_res_i(sts_q[ST_RES]),
    .sts_hse_i(sts_q[ST_HSE]), .sts_hpe_i(sts_q[ST_HPE]),
    .irq_o(irq_o)
  );

  assign run_o = cmd_q[CMD_RUN];

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (rd_i) begin
      case (rd_sel)
        RD_CMD:    rdata_o <= {16'h0000, cmd_q};
        RD_STS:    rdata_o <= 32'(sts_q);
        RD_IEN:    rdata_o <= {16'h0000, ien_q};
        RD_FRN:    rdata_o <= 32'(frame_no_o);
        RD_BASE:   rdata_o <= {base_q, {BASE_ALIGN{1'b0}}};
        RD_SOF:    rdata_o <= 32'(sof_q);
        RD_ONES_B: rdata_o <= 32'h0000_00FF;
        RD_ONES_W: rdata_o <= 32'h0000_FF7F;
        default:   rdata_o <= 32'hFFFF_FFFF;
      endcase
    end
  end

  // R8
  hse_set_chk: assert property (@(posedge clk) disable iff (rst)
    (host_err_i && !soft_rst) |=> sts_q[ST_HSE]);

  // R3
  halt_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !soft_rst && !wdata_i[CMD_RUN]) |=> sts_q[ST_HALT]);

  // R4
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (cmd_q == 16'h0 && ien_q == 16'h0 && sof_q == SOF_DEF));

  // R5
  cause_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sts && wdata_i[ST_INT] && !(frame_tick_i && frame_cause_i != 2'b00))
      |=> (cause_q == 2'b00));
endmodule

// File: tb/usbh_regfile_bench.sv
module usbh_regfile_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        wr_i = 0, rd_i = 0;
  logic [15:0] addr_i = 0;
  logic [1:0]  size_i = 0;
  logic [31:0] wdata_i = 0;
  logic [31:0] rdata_o;
  logic        run_o, irq_o;
  logic        frame_tick_i = 0, xfer_err_i = 0, host_err_i = 0, proc_err_i = 0, resume_i = 0;
  logic [1:0]  frame_cause_i = 0;
  logic [10:0] frame_no_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic rd_d = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  usbh_regfile u_usbh_regfile (
    .clk(clk), .rst(rst), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .run_o(run_o),
    .frame_tick_i(frame_tick_i), .frame_cause_i(frame_cause_i),
    .xfer_err_i(xfer_err_i), .host_err_i(host_err_i), .proc_err_i(proc_err_i),
    .resume_i(resume_i), .frame_no_o(frame_no_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_d <= rd_i;

  // monitor: pops expected read data the cycle after each read strobe
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata_o !== e) begin
        failures++;
        $display("FAIL %s: read got %h expected %h", t, rdata_o, e);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_i = 1; addr_i = a; size_i = s; wdata_i = d;
    @(negedge clk);
    wr_i = 0;
  endtask

  task automatic rd_exp(input logic [15:0] a, input logic [1:0] s,
                        input logic [31:0] e, input string t);
    @(negedge clk);
    rd_i = 1; addr_i = a; size_i = s;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_i = 0;
  endtask

  task automatic irq_exp(input logic e, input string t);
    @(negedge clk);
    chk(32'(irq_o), 32'(e), t);
  endtask

  task automatic tick(input logic [1:0] m);
    @(negedge clk);
    frame_tick_i = 1; frame_cause_i = m;
    @(negedge clk);
    frame_tick_i = 0; frame_cause_i = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: xfer_err_i = 1;
      1: host_err_i = 1;
      2: proc_err_i = 1;
      default: resume_i = 1;
    endcase
    @(negedge clk);
    xfer_err_i = 0; host_err_i = 0; proc_err_i = 0; resume_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(32'(irq_o), 0, "R1 irq");
    chk(32'(run_o), 0, "R1 run");
    rd_exp(16'h00, 1, 32'h0, "R1 cmd");
    rd_exp(16'h02, 1, 32'h0, "R1 status");
    rd_exp(16'h04, 1, 32'h0, "R1 ien");
    rd_exp(16'h06, 1, 32'h0, "R1 frame");
    rd_exp(16'h08, 2, 32'h0, "R1 base");
    rd_exp(16'h0C, 0, 32'h40, "R1 sof");
    // R2 decode
    rd_exp(16'h10, 1, 32'hFF7F, "R2 word unimpl");
    rd_exp(16'h00, 0, 32'hFF, "R2 byte unimpl");
    rd_exp(16'h00, 2, 32'hFFFFFFFF, "R2 dword unimpl");
    rd_exp(16'h0C, 3, 32'hFFFFFFFF, "R2 size3");
    wr(16'h00, 0, 32'h1);
    chk(32'(run_o), 0, "R2 byte cmd ignored");
    rd_exp(16'h00, 1, 32'h0, "R2 byte cmd ignored");
    wr(16'h0C, 1, 32'h55);
    rd_exp(16'h0C, 0, 32'h40, "R2 word sof ignored");
    wr(16'h2C, 0, 32'h33);
    rd_exp(16'h4C, 0, 32'h33, "R2 alias mod 32");
    // R6 frame number guarded by halted
    wr(16'h06, 1, 32'h123);
    rd_exp(16'h06, 1, 32'h0, "R6 load refused while not halted");
    wr(16'h00, 1, 32'h0);
    rd_exp(16'h02, 1, 32'h20, "R3 stop sets halted");
    wr(16'h06, 1, 32'hFFFF);
    rd_exp(16'h06, 1, 32'h7FF, "R6 load masked");
    tick(2'b00);
    rd_exp(16'h06, 1, 32'h0, "R6 wrap");
    tick(2'b00);
    rd_exp(16'h06, 1, 32'h1, "R6 increment");
    rd_exp(16'h02, 1, 32'h20, "R7 empty mask leaves status");
    // R3 run
    wr(16'h00, 1, 32'h9);
    chk(32'(run_o), 1, "R3 run high");
    rd_exp(16'h02, 1, 32'h0, "R3 start clears halted");
    rd_exp(16'h00, 1, 32'h9, "R3 cmd stored");
    wr(16'h06, 1, 32'h5);
    rd_exp(16'h06, 1, 32'h1, "R6 load refused while running");
    // R9 resume
    pulse(3);
    rd_exp(16'h00, 1, 32'h19, "R9 force resume bit");
    rd_exp(16'h02, 1, 32'h04, "R9 resume status");
    irq_exp(0, "R11 resume masked");
    wr(16'h04, 1, 32'h2);
    irq_exp(1, "R11 resume enabled");
    wr(16'h02, 1, 32'h4);
    irq_exp(0, "R5 resume cleared");
    // R7 causes
    tick(2'b01);
    rd_exp(16'h02, 1, 32'h01, "R7 status int");
    irq_exp(0, "R11 cause0 masked");
    wr(16'h04, 1, 32'h4);
    irq_exp(1, "R11 cause0 enabled");
    wr(16'h04, 1, 32'h8);
    irq_exp(0, "R11 cause1 absent");
    tick(2'b10);
    irq_exp(1, "R11 cause1 enabled");
    wr(16'h04, 1, 32'hC);
    wr(16'h02, 1, 32'h0);
    rd_exp(16'h02, 1, 32'h01, "R5 zero write keeps");
    wr(16'h02, 1, 32'h1);
    irq_exp(0, "R5 cause latch cleared");
    rd_exp(16'h02, 1, 32'h0, "R5 int cleared");
    rd_exp(16'h06, 1, 32'h3, "R6 count after ticks");
    // R8 errors
    pulse(0);
    rd_exp(16'h02, 1, 32'h02, "R8 xfer err");
    irq_exp(0, "R11 err masked");
    wr(16'h04, 1, 32'h1);
    irq_exp(1, "R11 err enabled");
    wr(16'h02, 1, 32'h2);
    irq_exp(0, "R5 err cleared");
    wr(16'h04, 1, 32'h0);
    pulse(1);
    rd_exp(16'h02, 1, 32'h08, "R8 host err");
    irq_exp(1, "R11 host err unmasked");
    wr(16'h02, 1, 32'h8);
    irq_exp(0, "R5 host err cleared");
    pulse(2);
    rd_exp(16'h02, 1, 32'h10, "R8 proc err");
    irq_exp(1, "R11 proc err unmasked");
    wr(16'h02, 1, 32'h10);
    irq_exp(0, "R5 proc err cleared");
    // R9 ignored without suspend bit
    wr(16'h00, 1, 32'h1);
    pulse(3);
    rd_exp(16'h00, 1, 32'h1, "R9 resume ignored cmd");
    rd_exp(16'h02, 1, 32'h0, "R9 resume ignored status");
    // R10
    wr(16'h08, 2, 32'h12345FFF);
    rd_exp(16'h08, 2, 32'h12345000, "R10 base aligned");
    wr(16'h0C, 0, 32'h20);
    rd_exp(16'h0C, 0, 32'h20, "R10 sof");
    // R3 stop
    wr(16'h00, 1, 32'h0);
    chk(32'(run_o), 0, "R3 run low");
    rd_exp(16'h02, 1, 32'h20, "R3 halted again");
    // R4 soft resets
    wr(16'h04, 1, 32'h3);
    wr(16'h00, 1, 32'h2);
    rd_exp(16'h00, 1, 32'h0, "R4 cmd default");
    rd_exp(16'h04, 1, 32'h0, "R4 ien default");
    rd_exp(16'h08, 2, 32'h0, "R4 base default");
    rd_exp(16'h0C, 0, 32'h40, "R4 sof default");
    rd_exp(16'h02, 1, 32'h0, "R4 status default");
    rd_exp(16'h06, 1, 32'h3, "R4 frame kept");
    wr(16'h0C, 0, 32'h10);
    wr(16'h00, 1, 32'h5);
    chk(32'(run_o), 0, "R4 global reset not run");
    rd_exp(16'h0C, 0, 32'h40, "R4 global reset sof");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule